// File: doc/BRIEF.md
# Ordered Host-Address Range Decoder Bank

This block holds a bank of programmable host-address range decoders. Each decoder has a base register, a size register and a control register. Software programs base and size and then requests a commit. The block validates the request in a fixed two-cycle sequence. The first step is the write that raises the request. The second step evaluates the rules and sets either the committed flag or the rejection flag.

The rules cover four things: commit ordering when the decoder is to be locked, address ordering against the decoder just below it, address-space wrap, and the zero-size case. A zero-size decoder may commit legally, but it never takes part in decode.

Committed decoders with non-zero size take part in a combinational lookup. An incoming address is compared against every such decoder. The lowest-numbered matching decoder is reported, together with a hit flag. Registers are reached through a plain write strobe and a combinational read port. Addresses and sizes are kept in 256 MiB granules.

Top module: `range_decoder_bank`

## Requirements
- R1: After reset every base, size and control register reads zero and the lookup reports no hit.
- R2: Base and size hold only whole granules. The low GRAN_W (28) bits read as zero, and write data in those bits is discarded.
- R3: The control register is decoded as follows: bit0 is the commit request, bit1 is lock-on-commit, bit2 is committed (read-only) and bit3 is commit error (read-only). Register select is reg_addr[1:0], with 0 = base, 1 = size and 2 = control. The decoder index is held in the upper reg_addr bits. A control write with bit0 set to an uncommitted decoder raises a request. On the second clock edge after the write, exactly one of committed or error is set.
- R4: A request with lock set on decoder m > 0 fails with the error bit when decoder m-1 is not committed.
- R5: When decoder m-1 is committed, a non-zero-size request on decoder m fails if its base is below the end of m-1 (base plus size). A base equal to that end is accepted.
- R6: A non-zero-size request whose base plus size goes beyond the top of the address space fails. A range that ends exactly at the top is accepted.
- R7: A size-0 decoder commits without error whatever its base is, and it never produces a hit.
- R8: For the ordering check of the decoder above it, a committed size-0 decoder counts as ending at its own base.
- R9: While a decoder is committed with lock set, writes to its base, size and control registers have no effect.
- R10: A control write with bit0 clear to an unlocked committed decoder clears committed, and the decoder stops matching.
- R11: A new commit request clears an earlier error bit before the result is set.
- R12: A lookup hits on base <= address < base + size of a committed non-zero decoder. When ranges overlap, the lowest index is reported. A decoder begins matching in the cycle after its check resolves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 | Decoder index in the upper bits, register select in [1:0] |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Combinational read data for reg_addr |
| lk_addr | input | ADDR_W | Address to look up |
| lk_hit | output | 1 | Some committed non-zero decoder covers lk_addr |
| lk_idx | output | IDX_W | Lowest matching decoder index, valid with lk_hit |

## Verification
A commit check can resolve on the same clock edge at which a lookup on that decoder's range is being observed. The bench raises a commit and probes the lookup in the pending cycle, where it expects a miss. It probes again after the resolving edge, where it expects a hit on that index. A predecessor's state can also change in the window between a request and its evaluation. The bench changes a zero-size predecessor between requests and judges the later decoder's verdict against the predecessor's base as it stands at evaluation.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
   // register select codes in reg_addr[1:0]
   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_SIZE = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } rdb_sel_e;

   // control register bit positions
   localparam int CB_REQ  = 0;
   localparam int CB_LOCK = 1;
   localparam int CB_DONE = 2;
   localparam int CB_ERR  = 3;
   localparam int CTRL_W  = 4;
endpackage

// File: rtl/rdb_commit_check.sv
// Pure rule evaluation for one decoder's commit request.
module rdb_commit_check #(
   parameter int HW       = 20,
   parameter bit HAS_PREV = 1'b1
) (
   input  logic [HW-1:0] base_i,
   input  logic [HW-1:0] size_i,
   input  logic          lock_i,
   input  logic          prev_committed_i,
   input  logic [HW:0]   prev_end_i,
   output logic          ok_o
);
   localparam logic [HW:0] SPACE_TOP = {1'b1, {HW{1'b0}}};

   logic [HW:0] end_full;
   logic        zero_sz;
   logic        range_ok;
   logic        order_ok;
   logic        lock_ok;

   assign end_full = {1'b0, base_i} + {1'b0, size_i};
   assign zero_sz  = (size_i == '0);
   assign range_ok = zero_sz || (end_full <= SPACE_TOP);

   generate
      if (HAS_PREV) begin : g_prev
         assign order_ok = zero_sz || !prev_committed_i || ({1'b0, base_i} >= prev_end_i);
         assign lock_ok  = !lock_i || prev_committed_i;
      end else begin : g_first
         logic unused_prev;
         assign unused_prev = prev_committed_i ^ (^prev_end_i) ^ lock_i;
         assign order_ok    = 1'b1;
         assign lock_ok     = 1'b1;
      end
   endgenerate

   assign ok_o = range_ok && order_ok && lock_ok;
endmodule

// File: rtl/rdb_slot.sv
// One decoder: registers, commit sequencing and range match.
module rdb_slot #(
   parameter int HW       = 20,
   parameter bit HAS_PREV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_base_i,
   input  logic          we_size_i,
   input  logic          we_ctrl_i,
   input  logic [HW-1:0] wdata_hi_i,
   input  logic          wreq_i,
   input  logic          wlock_i,
   input  logic          prev_committed_i,
   input  logic [HW:0]   prev_end_i,
   input  logic [HW-1:0] lk_hi_i,
   output logic [HW-1:0] base_o,
   output logic [HW-1:0] size_o,
   output logic [HW:0]   end_o,
   output logic          req_o,
   output logic          lock_o,
   output logic          committed_o,
   output logic          error_o,
   output logic          match_o
);
   logic [HW-1:0] base_q, size_q;
   logic          req_q, lock_q, committed_q, error_q, pending_q;
   logic          frozen, check_ok, zero_sz;
   logic [HW:0]   end_full;

   assign frozen   = committed_q && lock_q;
   assign zero_sz  = (size_q == '0);
   assign end_full = {1'b0, base_q} + {1'b0, size_q};

   rdb_commit_check #(.HW(HW), .HAS_PREV(HAS_PREV)) u_chk (
      .base_i           (base_q),
      .size_i           (size_q),
      .lock_i           (lock_q),
      .prev_committed_i (prev_committed_i),
      .prev_end_i       (prev_end_i),
      .ok_o             (check_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q      <= '0;
         size_q      <= '0;
         req_q       <= 1'b0;
         lock_q      <= 1'b0;
         committed_q <= 1'b0;
         error_q     <= 1'b0;
         pending_q   <= 1'b0;
      end else begin
         if (pending_q) begin
            pending_q <= 1'b0;
            if (check_ok) committed_q <= 1'b1;
            else          error_q     <= 1'b1;
         end
         if (!frozen && !pending_q) begin
            if (we_base_i) base_q <= wdata_hi_i;
            if (we_size_i) size_q <= wdata_hi_i;
            if (we_ctrl_i) begin
               req_q <= wreq_i;
               if (wreq_i && !committed_q) begin
                  lock_q    <= wlock_i;
                  error_q   <= 1'b0;
                  pending_q <= 1'b1;
               end else if (!wreq_i) begin
                  lock_q      <= wlock_i;
                  committed_q <= 1'b0;
               end
            end
         end
      end
   end

   assign base_o      = base_q;
   assign size_o      = size_q;
   assign end_o       = zero_sz ? {1'b0, base_q} : end_full;
   assign req_o       = req_q;
   assign lock_o      = lock_q;
   assign committed_o = committed_q;
   assign error_o     = error_q;
   assign match_o     = committed_q && !zero_sz &&
                        ({1'b0, lk_hi_i} >= {1'b0, base_q}) &&
                        ({1'b0, lk_hi_i} <  end_full);

   // a pending request resolves on the next edge into exactly one verdict
   p_resolve_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pending_q |=> (!pending_q && (committed_q != error_q)));

   p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(committed_q && error_q));

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (committed_q && lock_q) |=> ($stable(base_q) && $stable(size_q) && committed_q && lock_q));

   p_zero_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (committed_q && size_q == '0) |-> !match_o);

   generate
      if (HAS_PREV) begin : g_lock_chk
         p_lock_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(committed_q) && lock_q) |-> $past(prev_committed_i));
      end
   endgenerate
endmodule

// File: rtl/rdb_pick.sv
// Lowest-index selection among matching decoders.
module rdb_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  match_i,
   output logic          hit_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match_i[i]) idx_o = IW'(i);
      end
   end
   assign hit_o = |match_i;
endmodule

// File: rtl/range_decoder_bank.sv
module range_decoder_bank
   import rdb_pkg::*;
#(
   parameter int NUM_DEC = 4,
   parameter int ADDR_W  = 48,
   parameter int GRAN_W  = 28,
   localparam int IDX_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
   localparam int RA_W   = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx
);
   localparam int HW = ADDR_W - GRAN_W;

   initial begin
      a_cfg_gran: assert (GRAN_W > 0 && GRAN_W < ADDR_W)
         else $fatal(1, "GRAN_W must lie inside ADDR_W");
      a_cfg_num: assert (NUM_DEC >= 1 && NUM_DEC <= (1 << IDX_W))
         else $fatal(1, "NUM_DEC out of range");
   end

   logic [IDX_W-1:0] dec_sel;
   rdb_sel_e         reg_sel;
   logic [HW-1:0]    wdata_hi, lk_hi;
   logic             unused_bits;

   assign dec_sel     = reg_addr[RA_W-1:2];
   assign reg_sel     = rdb_sel_e'(reg_addr[1:0]);
   assign wdata_hi    = reg_wdata[ADDR_W-1:GRAN_W];
   assign lk_hi       = lk_addr[ADDR_W-1:GRAN_W];
   assign unused_bits = (^reg_wdata[GRAN_W-1:CTRL_W]) ^ (^lk_addr[GRAN_W-1:0]) ^ reg_wdata[CB_ERR]
                        ^ reg_wdata[CB_DONE];

   logic [HW-1:0]      base_a [NUM_DEC];
   logic [HW-1:0]      size_a [NUM_DEC];
   logic [HW:0]        end_a  [NUM_DEC];
   logic [NUM_DEC-1:0] req_v, lock_v, done_v, err_v, match_v;

   generate
      for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
         logic          sel_me, prev_c;
         logic [HW:0]   prev_e;
         assign sel_me = reg_we && (dec_sel == IDX_W'(g));
         if (g == 0) begin : g_head
            assign prev_c = 1'b0;
            assign prev_e = '0;
         end else begin : g_link
            assign prev_c = done_v[g-1];
            assign prev_e = end_a[g-1];
         end

         rdb_slot #(.HW(HW), .HAS_PREV(g != 0)) u_slot (
            .clk              (clk),
            .rst_n            (rst_n),
            .we_base_i        (sel_me && reg_sel == SEL_BASE),
            .we_size_i        (sel_me && reg_sel == SEL_SIZE),
            .we_ctrl_i        (sel_me && reg_sel == SEL_CTRL),
            .wdata_hi_i       (wdata_hi),
            .wreq_i           (reg_wdata[CB_REQ]),
            .wlock_i          (reg_wdata[CB_LOCK]),
            .prev_committed_i (prev_c),
            .prev_end_i       (prev_e),
            .lk_hi_i          (lk_hi),
            .base_o           (base_a[g]),
            .size_o           (size_a[g]),
            .end_o            (end_a[g]),
            .req_o            (req_v[g]),
            .lock_o           (lock_v[g]),
            .committed_o      (done_v[g]),
            .error_o          (err_v[g]),
            .match_o          (match_v[g])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_DEC; i++) begin
         if (dec_sel == IDX_W'(i)) begin
            case (reg_sel)
               SEL_BASE: reg_rdata = {base_a[i], {GRAN_W{1'b0}}};
               SEL_SIZE: reg_rdata = {size_a[i], {GRAN_W{1'b0}}};
               SEL_CTRL: reg_rdata = ADDR_W'({err_v[i], done_v[i], lock_v[i], req_v[i]});
               default:  reg_rdata = '0;
            endcase
         end
      end
   end

   rdb_pick #(.N(NUM_DEC), .IW(IDX_W)) u_pick (
      .match_i (match_v),
      .hit_o   (lk_hit),
      .idx_o   (lk_idx)
   );

   // reported index really matches, and none below it does
   p_pick_lowest_r12: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (match_v[lk_idx] &&
                  ((match_v & ((NUM_DEC'(1) << lk_idx) - NUM_DEC'(1))) == '0)));

   p_miss_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (match_v == '0));
endmodule

// File: tb/sim_range_decoder_bank.sv
module sim_range_decoder_bank;
   localparam int AW = 48;
   localparam int GW = 28;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_we;
   logic [3:0]    reg_addr;
   logic [AW-1:0] reg_wdata;
   logic [AW-1:0] reg_rdata;
   logic [AW-1:0] lk_addr;
   logic          lk_hit;
   logic [1:0]    lk_idx;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   range_decoder_bank #(.NUM_DEC(4), .ADDR_W(AW), .GRAN_W(GW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx)
   );

   function automatic logic [AW-1:0] gr(longint n);
      return AW'(n) << GW;
   endfunction

   task automatic chk(string req, string what, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   task automatic do_reset();
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; lk_addr = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(int d, int s, logic [AW-1:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = {2'(d), 2'(s)}; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(int d, int s, output logic [AW-1:0] v);
      reg_addr = {2'(d), 2'(s)};
      #1 v = reg_rdata;
   endtask

   // ctrl write with request bit set, then wait for the resolving edge
   task automatic commit(int d, bit lock);
      wr(d, 2, AW'({lock, 1'b1}));
      @(negedge clk);
   endtask

   task automatic prog(int d, longint b, longint s);
      wr(d, 0, gr(b));
      wr(d, 1, gr(s));
   endtask

   task automatic ctrl_is(string req, int d, logic [3:0] exp);
      logic [AW-1:0] v;
      rd(d, 2, v);
      chk(req, $sformatf("ctrl[%0d]", d), longint'(v[3:0]), longint'(exp));
   endtask

   task automatic look(string req, longint g, bit hit, int idx);
      lk_addr = gr(g) + AW'(12345);
      #1;
      chk(req, $sformatf("hit@%0h", g), longint'(lk_hit), longint'(hit));
      if (hit) chk(req, $sformatf("idx@%0h", g), longint'(lk_idx), longint'(idx));
   endtask

   task automatic t_reset();
      logic [AW-1:0] v;
      do_reset();
      for (int d = 0; d < 4; d++) begin
         for (int s = 0; s < 3; s++) begin
            rd(d, s, v);
            chk("R1", $sformatf("reg %0d/%0d", d, s), longint'(v), 0);
         end
      end
      look("R1", 0, 1'b0, 0);
   endtask

   task automatic t_granule();
      logic [AW-1:0] v;
      do_reset();
      wr(1, 0, gr(5) | AW'(28'hFFF_FFFF));
      rd(1, 0, v);
      chk("R2", "base low bits", longint'(v), longint'(gr(5)));
      wr(1, 1, AW'(28'h123_4567));
      rd(1, 1, v);
      chk("R2", "size low-only write", longint'(v), 0);
   endtask

   task automatic t_lock_order();
      do_reset();
      prog(1, 1, 1);
      commit(1, 1'b1);
      ctrl_is("R4", 1, 4'b1011);
      prog(0, 0, 1);
      commit(0, 1'b1);
      ctrl_is("R3", 0, 4'b0111);
      commit(1, 1'b1);
      ctrl_is("R11", 1, 4'b0111);
   endtask

   task automatic t_order();
      do_reset();
      prog(0, 4, 4);
      commit(0, 1'b0);
      ctrl_is("R3", 0, 4'b0101);
      prog(1, 7, 1);
      commit(1, 1'b0);
      ctrl_is("R5", 1, 4'b1001);
      wr(1, 0, gr(8));
      commit(1, 1'b0);
      ctrl_is("R5", 1, 4'b0101);
   endtask

   task automatic t_wrap();
      do_reset();
      prog(0, 64'hFFFFF, 1);
      commit(0, 1'b0);
      ctrl_is("R6", 0, 4'b0101);
      wr(0, 2, '0);
      wr(0, 1, gr(2));
      commit(0, 1'b0);
      ctrl_is("R6", 0, 4'b1001);
   endtask

   task automatic t_zero();
      do_reset();
      prog(0, 4, 4);
      commit(0, 1'b0);
      prog(1, 0, 0);
      commit(1, 1'b0);
      ctrl_is("R7", 1, 4'b0101);
      look("R7", 0, 1'b0, 0);
      wr(1, 2, '0);
      ctrl_is("R10", 1, 4'b0000);
      wr(1, 0, gr(10));
      commit(1, 1'b0);
      prog(2, 9, 1);
      commit(2, 1'b0);
      ctrl_is("R8", 2, 4'b1001);
      wr(2, 0, gr(10));
      commit(2, 1'b0);
      ctrl_is("R8", 2, 4'b0101);
      look("R7", 10, 1'b1, 2);
   endtask

   task automatic t_freeze();
      logic [AW-1:0] v;
      do_reset();
      prog(0, 2, 2);
      commit(0, 1'b1);
      wr(0, 0, gr(7));
      rd(0, 0, v);
      chk("R9", "locked base", longint'(v), longint'(gr(2)));
      wr(0, 1, gr(9));
      rd(0, 1, v);
      chk("R9", "locked size", longint'(v), longint'(gr(2)));
      wr(0, 2, '0);
      ctrl_is("R9", 0, 4'b0111);
      look("R9", 3, 1'b1, 0);
   endtask

   task automatic t_uncommit();
      do_reset();
      prog(0, 2, 2);
      commit(0, 1'b0);
      look("R10", 3, 1'b1, 0);
      wr(0, 2, '0);
      ctrl_is("R10", 0, 4'b0000);
      look("R10", 3, 1'b0, 0);
   endtask

   task automatic t_lookup();
      do_reset();
      prog(1, 2, 2);
      commit(1, 1'b0);
      prog(0, 0, 8);
      // request write, then probe in the pending cycle
      wr(0, 2, AW'(1));
      look("R12", 3, 1'b1, 1);
      @(negedge clk);
      look("R12", 3, 1'b1, 0);
      look("R12", 2, 1'b1, 0);
      look("R12", 7, 1'b1, 0);
      look("R12", 8, 1'b0, 0);
      wr(0, 2, '0);
      look("R12", 3, 1'b1, 1);
      look("R12", 4, 1'b0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_granule();
      t_lock_order();
      t_order();
      t_wrap();
      t_zero();
      t_freeze();
      t_uncommit();
      t_lookup();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule